// File: doc/BRIEF.md
# Auto-Length Video Line Buffer

This block keeps the most recent scan lines of a raster pixel stream so that a two-dimensional window filter downstream can see, for every accepted pixel, the full vertical stack of that column. Stage 0 of the stack is the live pixel. Stage k holds the pixel in the same column from k lines earlier. The buffered lines form a chain: when a column is written, each stored line passes its old value in that column one line further down.

The line length is never configured. A column counter restarts on every horizontal sync strobe, and the number of pixels that reached the buffer in a line is recorded for that line. A per-stage validity mask comes with every output column. Stage k is flagged only if each of the k most recent lines of the current frame reached past this column. Vertical sync discards all recorded lines, so nothing from the previous frame is ever marked valid. Each line memory is one `MAX_LINE` deep. Pixels beyond that depth in a line are dropped.

A small state machine tracks the line in progress. `ST_BLANK` means no pixel has been taken since the last strobe. `ST_ACTIVE` means the line is filling. `ST_OVERRUN` means the memory depth was reached and further pixels are discarded. The transitions are as follows. BLANK→ACTIVE happens on an accepted pixel. ACTIVE→OVERRUN happens when the pixel in the last column is written. Any state goes to ACTIVE on a sync strobe that comes with a pixel, and to BLANK on a sync strobe that comes without one. Reset returns the machine to BLANK.

Top module: `line_stack_buf`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs show `out_valid` = 0 and `out_mask` = 0. All recorded line lengths are cleared.
- R2: A pixel is accepted when `ce` and `pix_en` are high and the line is not overrun. One cycle later `out_valid` is 1 and lane 0 (`out_col[PIX_W-1:0]`) equals that pixel.
- R3: The column of a pixel is the number of pixels accepted since the last `hs` or `vs` strobe. A pixel taken in a strobe cycle is column 0. Lane k (`out_col[k*PIX_W +: PIX_W]`) carries the pixel of the same column from the k-th most recent completed line.
- R4: `out_mask` bit 0 is 1 for every accepted pixel. Bit k is 1 only if bit k-1 is 1 and the k-th most recent completed line of the frame held more pixels than the current column. The mask is therefore a contiguous run of ones from bit 0.
- R5: An `hs` strobe that comes when no pixel has been accepted since the previous strobe does not complete a line. The recorded lines stay as they were.
- R6: A `vs` strobe clears every recorded line. A pixel accepted in the `vs` cycle is column 0 and has `out_mask` = 1.
- R7: In a cycle with `ce` high and `pix_en` low, no pixel is stored and `out_valid` is 0 on the next cycle. Later columns and lines are unaffected.
- R8: While `ce` is low, `pix_en`, `hs`, `vs` and `pix_in` are ignored, and `out_valid`, `out_col` and `out_mask` hold their values.
- R9: `rst` acts even while `ce` is low.
- R10: Once `MAX_LINE` pixels have been taken in a line, further pixels of that line are dropped and produce no `out_valid`. That line is recorded with length `MAX_LINE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, overrides ce |
| ce | input | 1 | Clock enable; low freezes the block |
| pix_en | input | 1 | Pixel present on pix_in |
| hs | input | 1 | Horizontal sync strobe, starts a line |
| vs | input | 1 | Vertical sync strobe, starts a frame |
| pix_in | input | PIX_W | Incoming pixel |
| out_valid | output | 1 | Output column carries a newly accepted pixel |
| out_col | output | WIN_H*PIX_W | Column stack, lane 0 live, lane k from k lines earlier |
| out_mask | output | WIN_H | Per-lane validity, bit k for lane k |

## Verification
The embedded properties check a set of invariants on every cycle. They check that the output is frozen while the enable is low and that reset clears the outputs. They check that the mask is always a run of ones starting at the live lane, that a vertical strobe wipes the first recorded length, and that an empty horizontal strobe leaves it alone. They also check that the overrun state and the saturated column counter agree. The pixel values on the delayed lanes, the effect of lines of differing length on the mask, and the dropped pixels of an over-long line show up only in the bench scenarios. Those scenarios compare every output column against a line-history model.

// File: rtl/line_stack_pkg.sv
package line_stack_pkg;

    typedef enum logic [1:0] {
        ST_BLANK    = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_OVERRUN  = 2'd2
    } line_state_t;

endpackage

// File: rtl/line_stack_mem.sv
module line_stack_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] store [DEPTH];

    // old contents are read in the same cycle the new value is written
    assign rdata = store[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

endmodule

// File: rtl/line_stack_ctrl.sv
module line_stack_ctrl
    import line_stack_pkg::*;
#(
    parameter int WIN_H    = 3,
    parameter int MAX_LINE = 2048,
    parameter int AW       = $clog2(MAX_LINE),
    parameter int CW       = $clog2(MAX_LINE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             pix_en,
    input  logic             hs,
    input  logic             vs,
    output logic             wr_en,
    output logic [AW-1:0]    addr,
    output logic [WIN_H-1:0] mask_nxt
);

    localparam int NBUF = WIN_H - 1;

    line_state_t     state_q, state_d;
    logic [CW-1:0]   col_q, col_d;
    logic [CW-1:0]   len_q   [NBUF];
    logic [CW-1:0]   len_eff [NBUF];
    logic            strobe;
    logic            line_end;

    assign strobe   = hs || vs;
    assign line_end = hs && !vs && (col_q != '0);
    assign addr     = strobe ? '0 : col_q[AW-1:0];

    // recorded line lengths as they stand after this cycle's strobes
    generate
        for (genvar i = 0; i < NBUF; i++) begin : g_len
            if (i == 0) begin : g_first
                assign len_eff[i] = vs ? '0 : (line_end ? col_q : len_q[i]);
            end else begin : g_rest
                assign len_eff[i] = vs ? '0 : (line_end ? len_q[i-1] : len_q[i]);
            end
            assign mask_nxt[i+1] = mask_nxt[i] && (CW'(addr) < len_eff[i]);
        end
    endgenerate
    assign mask_nxt[0] = 1'b1;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (strobe) begin
            state_d = pix_en ? ST_ACTIVE : ST_BLANK;
        end else begin
            unique case (state_q)
                ST_BLANK:   if (pix_en) state_d = ST_ACTIVE;
                ST_ACTIVE:  if (pix_en && col_q == CW'(MAX_LINE - 1)) state_d = ST_OVERRUN;
                ST_OVERRUN: state_d = ST_OVERRUN;
                default:    state_d = ST_BLANK;
            endcase
        end
    end

    // output process
    always_comb begin
        wr_en = ce && !rst && pix_en && (strobe || state_q != ST_OVERRUN);
        col_d = strobe ? '0 : col_q;
        if (wr_en) begin
            col_d = CW'(addr) + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BLANK;
            col_q   <= '0;
            for (int i = 0; i < NBUF; i++) len_q[i] <= '0;
        end else if (ce) begin
            state_q <= state_d;
            col_q   <= col_d;
            for (int i = 0; i < NBUF; i++) len_q[i] <= len_eff[i];
        end
    end

    a_r10_overrun_saturated: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVERRUN) |-> (col_q == CW'(MAX_LINE)));

    a_r10_col_bound: assert property (@(posedge clk) disable iff (rst)
        col_q <= CW'(MAX_LINE));

    a_r6_vs_clears: assert property (@(posedge clk) disable iff (rst)
        (ce && vs) |=> (len_q[0] == '0));

    a_r5_empty_hs: assert property (@(posedge clk) disable iff (rst)
        (ce && hs && !vs && col_q == '0) |=> $stable(len_q[0]));

endmodule

// File: rtl/line_stack_buf.sv
module line_stack_buf #(
    parameter int PIX_W    = 8,
    parameter int WIN_H    = 3,
    parameter int MAX_LINE = 2048
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic                   pix_en,
    input  logic                   hs,
    input  logic                   vs,
    input  logic [PIX_W-1:0]       pix_in,
    output logic                   out_valid,
    output logic [WIN_H*PIX_W-1:0] out_col,
    output logic [WIN_H-1:0]       out_mask
);

    localparam int NBUF = WIN_H - 1;
    localparam int AW   = $clog2(MAX_LINE);
    localparam int CW   = $clog2(MAX_LINE + 1);

    logic             wr_en;
    logic [AW-1:0]    addr;
    logic [WIN_H-1:0] mask_nxt;
    logic [PIX_W-1:0] rd [NBUF];

    line_stack_ctrl #(
        .WIN_H    (WIN_H),
        .MAX_LINE (MAX_LINE),
        .AW       (AW),
        .CW       (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .pix_en   (pix_en),
        .hs       (hs),
        .vs       (vs),
        .wr_en    (wr_en),
        .addr     (addr),
        .mask_nxt (mask_nxt)
    );

    generate
        for (genvar k = 0; k < NBUF; k++) begin : g_line
            logic [PIX_W-1:0] wd;
            if (k == 0) begin : g_head
                assign wd = pix_in;
            end else begin : g_chain
                assign wd = rd[k-1];
            end
            line_stack_mem #(
                .W     (PIX_W),
                .DEPTH (MAX_LINE),
                .AW    (AW)
            ) u_mem (
                .clk   (clk),
                .we    (wr_en),
                .addr  (addr),
                .wdata (wd),
                .rdata (rd[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else if (ce) begin
            out_valid <= wr_en;
            if (wr_en) begin
                out_mask <= mask_nxt;
                out_col[PIX_W-1:0] <= pix_in;
                for (int k = 0; k < NBUF; k++) begin
                    out_col[(k+1)*PIX_W +: PIX_W] <= rd[k];
                end
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_mask == '0));

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ce && !rst) |=> ($stable(out_valid) && $stable(out_col) && $stable(out_mask)));

    a_r4_contiguous: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_mask[0] && ((out_mask & (out_mask + 1'b1)) == '0)));

    a_r2_strobe_pixel: assert property (@(posedge clk) disable iff (rst)
        (ce && pix_en && (hs || vs)) |=> out_valid);

endmodule

// File: tb/tb_line_stack_buf.sv
`timescale 1ns/1ps
module tb_line_stack_buf;

    localparam int PW   = 8;
    localparam int WH   = 4;
    localparam int MAXL = 16;

    logic              clk = 1'b0;
    logic              rst, ce, pix_en, hs, vs;
    logic [PW-1:0]     pix_in;
    logic              out_valid;
    logic [WH*PW-1:0]  out_col;
    logic [WH-1:0]     out_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    line_stack_buf #(.PIX_W(PW), .WIN_H(WH), .MAX_LINE(MAXL)) dut (
        .clk(clk), .rst(rst), .ce(ce), .pix_en(pix_en), .hs(hs), .vs(vs),
        .pix_in(pix_in), .out_valid(out_valid), .out_col(out_col), .out_mask(out_mask)
    );

    // line-history model
    logic [PW-1:0] rows [WH][MAXL];
    logic [PW-1:0] cur  [MAXL];
    int            lens [WH];
    int            mcol;
    logic          e_valid;
    logic [PW-1:0] e_col [WH];
    logic [WH-1:0] e_mask;

    task automatic fail_line(input string tag, input string what, input int got, input int exp);
        fails++;
        $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    endtask

    task automatic cyc(input logic r, input logic c, input logic p, input logic h,
                       input logic v, input logic [PW-1:0] d, input string tag);
        @(negedge clk);
        rst = r; ce = c; pix_en = p; hs = h; vs = v; pix_in = d;
        if (r) begin
            mcol = 0; e_valid = 0; e_mask = '0;
            for (int k = 0; k < WH; k++) lens[k] = 0;
        end else if (c) begin
            if (v) begin
                for (int k = 0; k < WH; k++) lens[k] = 0;
                mcol = 0;
            end else if (h) begin
                if (mcol > 0) begin
                    for (int k = WH - 1; k >= 2; k--) begin
                        rows[k] = rows[k-1];
                        lens[k] = lens[k-1];
                    end
                    rows[1] = cur;
                    lens[1] = mcol;
                end
                mcol = 0;
            end
            e_valid = 0;
            if (p && mcol < MAXL) begin
                e_valid  = 1;
                e_col[0] = d;
                e_mask   = '0;
                e_mask[0] = 1'b1;
                for (int k = 1; k < WH; k++) begin
                    if (e_mask[k-1] && lens[k] > mcol) begin
                        e_mask[k] = 1'b1;
                        e_col[k]  = rows[k][mcol];
                    end
                end
                cur[mcol] = d;
                mcol++;
            end
        end
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== e_valid) fail_line(tag, "out_valid", int'(out_valid), int'(e_valid));
        checks++;
        if (out_mask !== e_mask) fail_line(tag, "out_mask", int'(out_mask), int'(e_mask));
        if (e_valid) begin
            for (int k = 0; k < WH; k++) begin
                if (e_mask[k]) begin
                    checks++;
                    if (out_col[k*PW +: PW] !== e_col[k])
                        fail_line(tag, $sformatf("lane %0d", k), int'(out_col[k*PW +: PW]), int'(e_col[k]));
                end
            end
        end
    endtask

    task automatic run_line(input int n, input bit with_vs, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(0, 1, 1, (i == 0) && !with_vs, (i == 0) && with_vs, PW'($urandom), tag);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1; ce = 1; pix_en = 0; hs = 0; vs = 0; pix_in = '0;
        // R1: reset state
        cyc(1, 1, 0, 0, 0, 8'h00, "R1");
        cyc(1, 1, 1, 0, 0, 8'h11, "R1");
        // frame of equal-length lines, R2 and R3
        run_line(6, 1, "R3");
        run_line(6, 0, "R3");
        run_line(6, 0, "R3");
        run_line(6, 0, "R3");
        run_line(6, 0, "R2");
        // R7: gaps in pix_en inside a line
        cyc(0, 1, 1, 1, 0, 8'hA1, "R7");
        cyc(0, 1, 0, 0, 0, 8'hEE, "R7");
        cyc(0, 1, 1, 0, 0, 8'hA2, "R7");
        cyc(0, 1, 0, 0, 0, 8'h55, "R7");
        cyc(0, 1, 1, 0, 0, 8'hA3, "R7");
        // R8: ce low ignores every input
        cyc(0, 0, 1, 1, 1, 8'h77, "R8");
        cyc(0, 0, 1, 0, 0, 8'h78, "R8");
        cyc(0, 1, 1, 0, 0, 8'hA4, "R8");
        // R5: empty line between strobes
        cyc(0, 1, 0, 1, 0, 8'h00, "R5");
        cyc(0, 1, 0, 1, 0, 8'h00, "R5");
        run_line(4, 0, "R5");
        // R4: shorter line then longer line
        run_line(2, 0, "R4");
        run_line(6, 0, "R4");
        run_line(6, 0, "R4");
        // R10: over-long line drops excess pixels
        run_line(MAXL + 5, 0, "R10");
        run_line(MAXL, 0, "R10");
        // R6: frame restart mid line
        run_line(3, 0, "R6");
        cyc(0, 1, 1, 0, 1, 8'h6A, "R6");
        cyc(0, 1, 1, 0, 0, 8'h6B, "R6");
        run_line(4, 0, "R6");
        // R9: reset acts with ce low
        cyc(1, 0, 0, 0, 0, 8'h00, "R9");
        cyc(0, 1, 1, 1, 0, 8'h90, "R9");
        run_line(5, 0, "R9");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic c, p, h, v;
            c = ($urandom % 10) != 0;
            p = ($urandom % 4) != 0;
            h = ($urandom % 14) == 0;
            v = ($urandom % 300) == 0;
            cyc(0, c, p, h, v, PW'($urandom), "R2");
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule